// File: doc/BRIEF.md
# Dual Weekday and Daily Alarm

This block holds two alarm settings and compares them with the time of day
that a calendar counter elsewhere on the chip supplies. The weekly alarm is a
BCD minute, an hour code and a seven-bit day mask, so one setting can fire on
several days, for example Monday, Wednesday and Friday. The daily alarm is a
minute and an hour code and fires on every day.

The comparison runs once per minute, in the cycle where the seconds input
steps into 00. An alarm that is enabled and matches sets its own sticky flag.
The flag stays set until the host writes a 0 to it. Both alarms share one
active-low interrupt output. That output stays low while any alarm has both
its flag and its enable set. The host writes the alarm fields, the enables and
the flag clears through a small register port, and reads everything back
through a read port.

Top module: `dual_alarm`

## Requirements
- R1: After reset, both enables and both flags are 0, every register reads 0, and `irq_n` is 1.
- R2: The register map is: 0 weekly minute (7 bits), 1 weekly hour (6 bits), 2 weekly day mask (7 bits), 3 daily minute (7 bits), 4 daily hour (6 bits), 5 enables (bit 0 weekly, bit 1 daily), 6 flags (bit 0 weekly, bit 1 daily). Bits outside a field are not stored and read 0. Address 7 reads 0.
- R3: A comparison happens only in a cycle where `sec_bcd` is 00 and its value in the previous clock cycle was not 00. Holding the seconds at 00 does not compare again.
- R4: The weekly alarm matches when minute and hour are equal to the inputs and bit `wday` of the day mask is set (bit n stands for day n, 0 to 6). A `wday` of 7 never matches.
- R5: The daily alarm matches on minute and hour alone, on any `wday`.
- R6: A flag is set only when its enable is 1 at the comparison. A match while the alarm is disabled leaves the flag at 0.
- R7: A flag stays set until a write to address 6 has a 0 in the flag's bit. Writing a 1 there has no effect. When a set and a clear fall in the same cycle, the set wins.
- R8: `irq_n` is 0 exactly when some alarm has both its flag and its enable set. Clearing the enable releases `irq_n` in the next cycle, and the flag stays set.
- R9: The hour is compared as a raw 6-bit code, so the 12-hour PM bit (bit 5) is part of the match. For example, 0x21 does not match 0x01.
- R10: A register write takes effect at the next clock edge. A flag is set in the clock cycle after the comparison. `alarm_flags` shows the flags directly (bit 0 weekly).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 7 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 7 | Register read data (combinational) |
| sec_bcd | input | 7 | Current seconds, BCD |
| min_bcd | input | 7 | Current minutes, BCD |
| hour_code | input | 6 | Current hour in the counter's 12/24-hour encoding |
| wday | input | 3 | Current day of week, 0 to 6 |
| alarm_flags | output | 2 | Sticky alarm flags, bit 0 weekly, bit 1 daily |
| irq_n | output | 1 | Active-low interrupt, low-enable for an open-drain pad |

## Verification
The hardest thing to reach from the ports is a real match. For that, the minute, the hour and the day-mask bit must all agree with the stored settings in the single cycle where the seconds roll from a nonzero value into 00. On top of that, a flag clear or an enable change often has to land in that same cycle. Uniform random time values almost never produce this. So the random stimulus copies the minute and hour that the bench has recorded as written into the alarm registers, toggles the seconds between 59 and 00, and draws register writes in the same cycles. Directed cases cover the PM bit, the day that the mask leaves out, day 7, and a set meeting a clear in the same cycle.

// File: rtl/dual_alarm_pkg.sv
package dual_alarm_pkg;
  localparam int DATA_W    = 7;
  localparam int ADDR_W    = 3;
  localparam int SEC_W     = 7;
  localparam int MIN_W     = 7;
  localparam int HOUR_W    = 6;
  localparam int NUM_DAYS  = 7;
  localparam int DAY_IDX_W = 3;
  localparam int NUM_ALM   = 2;
  localparam int DAY_SPAN  = 1 << DAY_IDX_W;

  typedef enum logic [ADDR_W-1:0] {
    RA_WK_MIN  = 3'd0,
    RA_WK_HOUR = 3'd1,
    RA_WK_DAYS = 3'd2,
    RA_DY_MIN  = 3'd3,
    RA_DY_HOUR = 3'd4,
    RA_ENABLE  = 3'd5,
    RA_FLAGS   = 3'd6
  } reg_addr_e;

  typedef struct packed {
    logic [MIN_W-1:0]    min;
    logic [HOUR_W-1:0]   hour;
    logic [NUM_DAYS-1:0] days;
  } alarm_cfg_t;
endpackage

// File: rtl/alarm_rst_sync.sv
module alarm_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/alarm_minute_tick.sv
module alarm_minute_tick
  import dual_alarm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEC_W-1:0] sec_bcd,
  output logic             tick
);
  logic [SEC_W-1:0] prev_q;
  logic [SEC_W-1:0] prev_d;

  always_comb begin
    prev_d = sec_bcd;
    tick   = (sec_bcd == '0) && (prev_q != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= prev_d;
  end

  AST_TICK_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick) else $error("tick repeated"); // R3
endmodule

// File: rtl/alarm_regs.sv
module alarm_regs
  import dual_alarm_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0]  rd_addr,
  input  logic [NUM_ALM-1:0] flags,
  output logic [DATA_W-1:0]  rd_data,
  output alarm_cfg_t         wk_cfg,
  output alarm_cfg_t         dy_cfg,
  output logic [NUM_ALM-1:0] alm_en,
  output logic [NUM_ALM-1:0] flag_clr
);
  alarm_cfg_t         wk_q, wk_d, dy_q, dy_d;
  logic [NUM_ALM-1:0] en_q, en_d;
  logic               wk_we, dy_we, en_we;

  always_comb begin
    wk_d  = wk_q;
    dy_d  = dy_q;
    en_d  = en_q;
    wk_we = 1'b0;
    dy_we = 1'b0;
    en_we = 1'b0;
    if (wr_en) begin
      unique case (wr_addr)
        RA_WK_MIN:  begin wk_we = 1'b1; wk_d.min  = wr_data[MIN_W-1:0];    end
        RA_WK_HOUR: begin wk_we = 1'b1; wk_d.hour = wr_data[HOUR_W-1:0];   end
        RA_WK_DAYS: begin wk_we = 1'b1; wk_d.days = wr_data[NUM_DAYS-1:0]; end
        RA_DY_MIN:  begin dy_we = 1'b1; dy_d.min  = wr_data[MIN_W-1:0];    end
        RA_DY_HOUR: begin dy_we = 1'b1; dy_d.hour = wr_data[HOUR_W-1:0];   end
        RA_ENABLE:  begin en_we = 1'b1; en_d      = wr_data[NUM_ALM-1:0];  end
        default:    ;
      endcase
    end
    dy_d.days = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wk_q <= '0;
      dy_q <= '0;
      en_q <= '0;
    end else begin
      if (wk_we) wk_q <= wk_d;
      if (dy_we) dy_q <= dy_d;
      if (en_we) en_q <= en_d;
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_ALM; i++)
      flag_clr[i] = wr_en && (wr_addr == RA_FLAGS) && !wr_data[i];
  end

  always_comb begin
    rd_data = '0;
    unique case (rd_addr)
      RA_WK_MIN:  rd_data[MIN_W-1:0]    = wk_q.min;
      RA_WK_HOUR: rd_data[HOUR_W-1:0]   = wk_q.hour;
      RA_WK_DAYS: rd_data[NUM_DAYS-1:0] = wk_q.days;
      RA_DY_MIN:  rd_data[MIN_W-1:0]    = dy_q.min;
      RA_DY_HOUR: rd_data[HOUR_W-1:0]   = dy_q.hour;
      RA_ENABLE:  rd_data[NUM_ALM-1:0]  = en_q;
      RA_FLAGS:   rd_data[NUM_ALM-1:0]  = flags;
      default:    ;
    endcase
  end

  assign wk_cfg = wk_q;
  assign dy_cfg = dy_q;
  assign alm_en = en_q;

  AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_addr == RA_ENABLE) |=> $stable(en_q)) else $error("enable moved"); // R2
endmodule

// File: rtl/alarm_match.sv
module alarm_match
  import dual_alarm_pkg::*;
#(
  parameter bit HAS_DAYS = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 en,
  input  logic                 clr,
  input  alarm_cfg_t           cfg,
  input  logic [MIN_W-1:0]     cur_min,
  input  logic [HOUR_W-1:0]    cur_hour,
  input  logic [DAY_IDX_W-1:0] cur_wday,
  output logic                 flag
);
  logic [DAY_SPAN-1:0] days_ext;
  logic                day_ok, time_eq, hit;
  logic                flag_q, flag_d;

  always_comb begin
    days_ext = {{(DAY_SPAN-NUM_DAYS){1'b0}}, cfg.days};
    day_ok   = !HAS_DAYS || days_ext[cur_wday];
    time_eq  = (cur_min == cfg.min) && (cur_hour == cfg.hour);
    hit      = tick && en && time_eq && day_ok;
    if (hit)      flag_d = 1'b1;
    else if (clr) flag_d = 1'b0;
    else          flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag = flag_q;

  AST_SET_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(tick && en)) else $error("flag set without enable"); // R6
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr) |=> flag_q) else $error("flag lost"); // R7

  generate
    if (HAS_DAYS) begin : g_day_chk
      AST_DAY_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(days_ext[cur_wday])) else $error("day not in mask"); // R4
    end
  endgenerate
endmodule

// File: rtl/dual_alarm.sv
module dual_alarm
  import dual_alarm_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [DATA_W-1:0]    wr_data,
  input  logic [ADDR_W-1:0]    rd_addr,
  output logic [DATA_W-1:0]    rd_data,
  input  logic [SEC_W-1:0]     sec_bcd,
  input  logic [MIN_W-1:0]     min_bcd,
  input  logic [HOUR_W-1:0]    hour_code,
  input  logic [DAY_IDX_W-1:0] wday,
  output logic [NUM_ALM-1:0]   alarm_flags,
  output logic                 irq_n
);
  logic               rst_q_n;
  logic               tick;
  alarm_cfg_t         cfg [NUM_ALM];
  logic [NUM_ALM-1:0] alm_en, flag_clr, flags;

  alarm_rst_sync i_rst (
    .clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_q_n)
  );

  alarm_minute_tick i_tick (
    .clk(clk), .rst_n(rst_q_n), .sec_bcd(sec_bcd), .tick(tick)
  );

  alarm_regs i_regs (
    .clk(clk), .rst_n(rst_q_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .flags(flags), .rd_data(rd_data),
    .wk_cfg(cfg[0]), .dy_cfg(cfg[1]),
    .alm_en(alm_en), .flag_clr(flag_clr)
  );

  generate
    for (genvar g = 0; g < NUM_ALM; g++) begin : g_alm
      alarm_match #(.HAS_DAYS(g == 0)) i_match (
        .clk(clk), .rst_n(rst_q_n), .tick(tick),
        .en(alm_en[g]), .clr(flag_clr[g]), .cfg(cfg[g]),
        .cur_min(min_bcd), .cur_hour(hour_code), .cur_wday(wday),
        .flag(flags[g])
      );
    end
  endgenerate

  assign alarm_flags = flags;
  assign irq_n       = ~|(flags & alm_en);

  AST_IRQ_IDLE: assert property (@(posedge clk) disable iff (!rst_q_n)
    (alm_en == '0) |-> irq_n) else $error("irq with no enable"); // R8
  AST_IRQ_RELEASE: assert property (@(posedge clk) disable iff (!rst_q_n)
    $fell(alm_en[0]) && !alm_en[1] |-> irq_n) else $error("irq held"); // R8
endmodule

// File: tb/test_dual_alarm.sv
module test_dual_alarm;
  localparam int PER = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [2:0] wr_addr, rd_addr, wday;
  logic [6:0] wr_data, rd_data, sec_bcd, min_bcd;
  logic [5:0] hour_code;
  logic [1:0] alarm_flags;
  logic       irq_n;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [6:0] m_wmin, m_days, m_dmin, m_prev;
  logic [5:0] m_whr, m_dhr;
  logic       m_wen, m_den, m_wf, m_df;
  logic [6:0] t_s, t_m;
  logic [5:0] t_h;
  logic [2:0] t_d, t_ra;

  always #(PER/2) clk = ~clk;

  dual_alarm i_dual_alarm (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .sec_bcd(sec_bcd), .min_bcd(min_bcd), .hour_code(hour_code),
    .wday(wday), .alarm_flags(alarm_flags), .irq_n(irq_n)
  );

  function automatic logic [6:0] exp_rd(input logic [2:0] a);
    case (a)
      3'd0:    return m_wmin;
      3'd1:    return {1'b0, m_whr};
      3'd2:    return m_days;
      3'd3:    return m_dmin;
      3'd4:    return {1'b0, m_dhr};
      3'd5:    return {5'b0, m_den, m_wen};
      3'd6:    return {5'b0, m_df, m_wf};
      default: return 7'd0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic model(input logic we, input logic [2:0] wa, input logic [6:0] wd);
    logic tk, wh, dh;
    tk = (t_s == 7'h00) && (m_prev != 7'h00);
    wh = tk && m_wen && t_m == m_wmin && t_h == m_whr && t_d < 3'd7 && m_days[t_d];
    dh = tk && m_den && t_m == m_dmin && t_h == m_dhr;
    if (wh) m_wf = 1'b1; else if (we && wa == 3'd6 && !wd[0]) m_wf = 1'b0;
    if (dh) m_df = 1'b1; else if (we && wa == 3'd6 && !wd[1]) m_df = 1'b0;
    if (we) begin
      case (wa)
        3'd0: m_wmin = wd;
        3'd1: m_whr  = wd[5:0];
        3'd2: m_days = wd;
        3'd3: m_dmin = wd;
        3'd4: m_dhr  = wd[5:0];
        3'd5: {m_den, m_wen} = wd[1:0];
        default: ;
      endcase
    end
    m_prev = t_s;
  endtask

  task automatic cyc(input string tag, input logic we, input logic [2:0] wa, input logic [6:0] wd);
    @(negedge clk);
    wr_en = we; wr_addr = wa; wr_data = wd; rd_addr = t_ra;
    sec_bcd = t_s; min_bcd = t_m; hour_code = t_h; wday = t_d;
    model(we, wa, wd);
    @(posedge clk);
    #(PER/4);
    chk({tag, " rd_data"}, {1'b0, rd_data}, {1'b0, exp_rd(t_ra)});
    chk({tag, " flags"}, {6'b0, alarm_flags}, {6'b0, m_df, m_wf});
    chk({tag, " irq_n"}, {7'b0, irq_n}, {7'b0, !((m_wf && m_wen) || (m_df && m_den))});
  endtask

  task automatic wr(input string tag, input logic [2:0] a, input logic [6:0] d);
    cyc(tag, 1'b1, a, d);
  endtask

  task automatic tm(input string tag, input logic [6:0] s, input logic [6:0] m,
                    input logic [5:0] h, input logic [2:0] d);
    t_s = s; t_m = m; t_h = h; t_d = d;
    cyc(tag, 1'b0, 3'd0, 7'd0);
  endtask

  initial begin
    #(PER * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hang expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    sec_bcd = 7'h10; min_bcd = '0; hour_code = '0; wday = '0;
    m_wmin = '0; m_days = '0; m_dmin = '0; m_whr = '0; m_dhr = '0;
    m_wen = 0; m_den = 0; m_wf = 0; m_df = 0; m_prev = 7'h00;
    t_s = 7'h10; t_m = '0; t_h = '0; t_d = '0; t_ra = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    m_prev = 7'h10;

    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      t_ra = 3'(a);
      cyc("R1", 1'b0, 3'd0, 7'd0);
      chk("R1 reset read", {1'b0, rd_data}, 8'h00);
    end
    chk("R1 irq_n", {7'b0, irq_n}, 8'h01);

    // R2 field masking
    t_ra = 3'd1;
    wr("R2", 3'd1, 7'h7F);
    chk("R2 hour mask", {1'b0, rd_data}, 8'h3F);
    t_ra = 3'd6;
    wr("R2", 3'd0, 7'h30);
    wr("R2", 3'd1, 7'h21);
    wr("R2", 3'd2, 7'b0001010);
    wr("R2", 3'd3, 7'h30);
    wr("R2", 3'd4, 7'h01);
    wr("R2", 3'd5, 7'h03);

    // R5 R9 daily matches at 01:30, weekly 0x21 does not
    tm("R5", 7'h59, 7'h30, 6'h01, 3'd1);
    tm("R5", 7'h00, 7'h30, 6'h01, 3'd1);
    chk("R5 R9 flags", {6'b0, alarm_flags}, 8'h02);
    chk("R8 irq low", {7'b0, irq_n}, 8'h00);
    wr("R7", 3'd6, 7'h01);
    chk("R7 clear daily", {6'b0, alarm_flags}, 8'h00);
    tm("R3", 7'h00, 7'h30, 6'h01, 3'd1);
    chk("R3 no retrigger", {6'b0, alarm_flags}, 8'h00);

    // R4 day mask
    tm("R4", 7'h59, 7'h30, 6'h21, 3'd2);
    tm("R4", 7'h00, 7'h30, 6'h21, 3'd2);
    chk("R4 day off", {6'b0, alarm_flags}, 8'h00);
    tm("R4", 7'h59, 7'h30, 6'h21, 3'd3);
    tm("R4", 7'h00, 7'h30, 6'h21, 3'd3);
    chk("R4 day on", {6'b0, alarm_flags}, 8'h01);
    wr("R7", 3'd6, 7'h7F);
    chk("R7 write one", {6'b0, alarm_flags}, 8'h01);
    wr("R8", 3'd5, 7'h02);
    chk("R8 release", {7'b0, irq_n}, 8'h01);
    chk("R8 flag kept", {6'b0, alarm_flags}, 8'h01);

    // R6 disabled match
    wr("R6", 3'd6, 7'h00);
    wr("R6", 3'd5, 7'h00);
    tm("R6", 7'h59, 7'h30, 6'h01, 3'd0);
    tm("R6", 7'h00, 7'h30, 6'h01, 3'd0);
    chk("R6 disabled", {6'b0, alarm_flags}, 8'h00);

    // R7 set beats clear in the same cycle
    wr("R7", 3'd5, 7'h02);
    tm("R7", 7'h59, 7'h30, 6'h01, 3'd0);
    t_s = 7'h00;
    wr("R7", 3'd6, 7'h00);
    chk("R7 set wins", {6'b0, alarm_flags}, 8'h02);

    // R4 day 7
    wr("R4", 3'd5, 7'h01);
    wr("R4", 3'd6, 7'h00);
    wr("R4", 3'd2, 7'h7F);
    tm("R4", 7'h59, 7'h30, 6'h21, 3'd7);
    tm("R4", 7'h00, 7'h30, 6'h21, 3'd7);
    chk("R4 day 7", {6'b0, alarm_flags}, 8'h00);

    // R2 R4 R5 R8 R10 random traffic biased toward matches
    seed = $urandom(32'h5EED1);
    for (int i = 0; i < 4000; i++) begin
      logic       we;
      logic [2:0] wa;
      logic [6:0] wd;
      we = ($urandom % 4) == 0;
      wa = 3'($urandom % 8);
      wd = 7'($urandom);
      case ($urandom % 3)
        0: t_s = 7'h00;
        1: t_s = 7'h59;
        default: t_s = 7'h30;
      endcase
      if ($urandom % 2) begin t_m = m_wmin; t_h = m_whr; end
      else if ($urandom % 2) begin t_m = m_dmin; t_h = m_dhr; end
      else begin t_m = 7'($urandom); t_h = 6'($urandom); end
      t_d  = 3'($urandom % 8);
      t_ra = 3'($urandom % 8);
      cyc("R2 R4 R5 R8 R10 random", we, wa, wd);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule